// File: doc/BRIEF.md
# Keyboard/Auxiliary Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the single output buffer that a host sees. Each source raises a level while it holds at least one byte for the host. From these two levels and the controller's mode byte, the block works out four things:

- the buffer-full bits of the status byte;
- the copy of those bits in the controller's output port;
- which source answers a data-port read;
- the two interrupt request levels.

The keyboard channel always has priority. The auxiliary channel is shown to the host only while it is the sole source with data. Status and port bits are combinational, so a neighbour can merge them into its own status and port bytes. The interrupt lines are registered levels. A read strobe is steered into a one-cycle pop pulse toward the source that is currently selected. The byte FIFOs and the mode register live outside the block.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: `stat_mask[0]` and `port_mask[4]` are 1 in the same cycle that `kbd_pend` or `aux_pend` is 1, and 0 when both are 0.
- R2: `stat_mask[5]` and `port_mask[5]` are 1 only when `aux_pend`=1 and `kbd_pend`=0. When both sources are pending, the keyboard wins and these bits are 0.
- R3: All other bits of `stat_mask` (1..4, 6, 7) and of `port_mask` (0..3, 6, 7) are always 0.
- R4: `irq_aux` is a registered level. After a clock edge it equals (`aux_pend`=1 and `kbd_pend`=0 and `mode[1]`=1), sampled at that edge.
- R5: `irq_kbd` is a registered level. After a clock edge it equals (`kbd_pend`=1 and `mode[0]`=1 and `mode[4]`=0), sampled at that edge. `mode[4]` is the keyboard-disable bit.
- R6: `rd_sel_aux` is 1 (auxiliary source) only when `aux_pend`=1 and `kbd_pend`=0. Otherwise it is 0 (keyboard source).
- R7: While `rd_strobe`=1, exactly one pop pulse is raised in the same cycle: `pop_aux` if `rd_sel_aux`=1, else `pop_kbd`. While `rd_strobe`=0, both pops are 0.
- R8: While `rst_n`=0, `irq_kbd` and `irq_aux` are 0, whatever the inputs.
- R9: Mode bits 2, 3, 5, 6 and 7 have no effect on any output. A change of `mode` alone, with the pending levels unchanged, updates the interrupt levels at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_pend | input | 1 | Keyboard source holds data |
| aux_pend | input | 1 | Auxiliary source holds data |
| mode | input | 8 | Controller mode byte |
| rd_strobe | input | 1 | Host reads the data port this cycle |
| stat_mask | output | 8 | Status bits contributed (bit 0 full, bit 5 aux full) |
| port_mask | output | 8 | Output port bits contributed (bit 4 full, bit 5 aux full) |
| rd_sel_aux | output | 1 | 1: data read served by auxiliary source |
| pop_kbd | output | 1 | Pop pulse to keyboard source |
| pop_aux | output | 1 | Pop pulse to auxiliary source |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |

## Verification
The assertions check on every cycle that:

- the two pop pulses are never both high;
- the aux-full bit implies the full bit;
- the port copy matches the status bits;
- the two interrupt lines are never both high;
- each interrupt level is justified by the pending levels and mode bits one edge earlier.

Only the bench's scenarios can show the converse: that an interrupt does rise when its conditions hold, that the unused mode bits change nothing, and that both sources pending gives the keyboard the buffer. The bench also shows that the interrupts stay low while reset is held with data pending.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
  typedef enum logic {SRC_KBD = 1'b0, SRC_AUX = 1'b1} src_e;

  typedef struct packed {
    logic any_full;
    logic aux_only;
  } present_t;
endpackage

// File: rtl/obuf_arb_present.sv
module obuf_arb_present
  import obuf_arb_pkg::*;
(
  input  logic     kbd_pend,
  input  logic     aux_pend,
  output present_t pres,
  output src_e     src
);
  always_comb begin
    pres.any_full = kbd_pend | aux_pend;
    pres.aux_only = aux_pend & ~kbd_pend;
    src = pres.aux_only ? SRC_AUX : SRC_KBD;
  end
endmodule

// File: rtl/obuf_arb_irq.sv
module obuf_arb_irq
  import obuf_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     kbd_pend,
  input  present_t pres,
  input  logic     kbd_ie,
  input  logic     aux_ie,
  input  logic     kbd_dis,
  output logic     irq_kbd,
  output logic     irq_aux
);
  logic kbd_nxt, aux_nxt, upd_en;

  always_comb begin
    kbd_nxt = kbd_pend & kbd_ie & ~kbd_dis;
    aux_nxt = pres.aux_only & aux_ie;
    upd_en  = (kbd_nxt != irq_kbd) | (aux_nxt != irq_aux);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_kbd <= 1'b0;
      irq_aux <= 1'b0;
    end else if (upd_en) begin
      irq_kbd <= kbd_nxt;
      irq_aux <= aux_nxt;
    end
  end
endmodule

// File: rtl/obuf_arb_pop.sv
module obuf_arb_pop
  import obuf_arb_pkg::*;
(
  input  logic rd_strobe,
  input  src_e src,
  output logic pop_kbd,
  output logic pop_aux
);
  always_comb begin
    pop_kbd = rd_strobe & (src == SRC_KBD);
    pop_aux = rd_strobe & (src == SRC_AUX);
  end
endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W        = 8,
  parameter int STAT_W        = 8,
  parameter int PORT_W        = 8,
  parameter int KIE_BIT       = 0,
  parameter int AIE_BIT       = 1,
  parameter int KDIS_BIT      = 4,
  parameter int STAT_FULL_BIT = 0,
  parameter int STAT_AUX_BIT  = 5,
  parameter int PORT_FULL_BIT = 4,
  parameter int PORT_AUX_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_pend,
  input  logic              aux_pend,
  input  logic [MODE_W-1:0] mode,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] stat_mask,
  output logic [PORT_W-1:0] port_mask,
  output logic              rd_sel_aux,
  output logic              pop_kbd,
  output logic              pop_aux,
  output logic              irq_kbd,
  output logic              irq_aux
);
  localparam logic [MODE_W-1:0] USED_MODE =
    (MODE_W'(1) << KIE_BIT) | (MODE_W'(1) << AIE_BIT) | (MODE_W'(1) << KDIS_BIT);

  present_t pres;
  src_e     src;
  logic     unused_mode_bits;

  assign unused_mode_bits = ^(mode & ~USED_MODE);

  obuf_arb_present u_present (
    .kbd_pend (kbd_pend),
    .aux_pend (aux_pend),
    .pres     (pres),
    .src      (src)
  );

  obuf_arb_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .kbd_pend (kbd_pend),
    .pres     (pres),
    .kbd_ie   (mode[KIE_BIT]),
    .aux_ie   (mode[AIE_BIT]),
    .kbd_dis  (mode[KDIS_BIT]),
    .irq_kbd  (irq_kbd),
    .irq_aux  (irq_aux)
  );

  obuf_arb_pop u_pop (
    .rd_strobe (rd_strobe),
    .src       (src),
    .pop_kbd   (pop_kbd),
    .pop_aux   (pop_aux)
  );

  assign rd_sel_aux = (src == SRC_AUX);

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == STAT_FULL_BIT) begin : g_full
      assign stat_mask[i] = pres.any_full;
    end else if (i == STAT_AUX_BIT) begin : g_aux
      assign stat_mask[i] = pres.aux_only;
    end else begin : g_zero
      assign stat_mask[i] = 1'b0;
    end
  end

  for (genvar j = 0; j < PORT_W; j++) begin : g_port
    if (j == PORT_FULL_BIT) begin : g_full
      assign port_mask[j] = pres.any_full;
    end else if (j == PORT_AUX_BIT) begin : g_aux
      assign port_mask[j] = pres.aux_only;
    end else begin : g_zero
      assign port_mask[j] = 1'b0;
    end
  end
endmodule

// File: rtl/obuf_irq_arbiter_chk.sv
module obuf_irq_arbiter_chk #(
  parameter int MODE_W        = 8,
  parameter int STAT_W        = 8,
  parameter int PORT_W        = 8,
  parameter int KIE_BIT       = 0,
  parameter int AIE_BIT       = 1,
  parameter int KDIS_BIT      = 4,
  parameter int STAT_FULL_BIT = 0,
  parameter int STAT_AUX_BIT  = 5,
  parameter int PORT_FULL_BIT = 4,
  parameter int PORT_AUX_BIT  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              kbd_pend,
  input logic              aux_pend,
  input logic [MODE_W-1:0] mode,
  input logic [STAT_W-1:0] stat_mask,
  input logic [PORT_W-1:0] port_mask,
  input logic              pop_kbd,
  input logic              pop_aux,
  input logic              irq_kbd,
  input logic              irq_aux
);
  p_pop_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_kbd, pop_aux}));

  p_aux_implies_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_mask[STAT_AUX_BIT] |-> stat_mask[STAT_FULL_BIT]);

  p_port_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_mask[PORT_FULL_BIT] == stat_mask[STAT_FULL_BIT]) &&
    (port_mask[PORT_AUX_BIT] == stat_mask[STAT_AUX_BIT]));

  p_irq_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux));

  p_aux_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> $past(aux_pend && !kbd_pend && mode[AIE_BIT]));

  p_kbd_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd |-> $past(kbd_pend && mode[KIE_BIT] && !mode[KDIS_BIT]));
endmodule

bind obuf_irq_arbiter obuf_irq_arbiter_chk #(
  .MODE_W(MODE_W), .STAT_W(STAT_W), .PORT_W(PORT_W),
  .KIE_BIT(KIE_BIT), .AIE_BIT(AIE_BIT), .KDIS_BIT(KDIS_BIT),
  .STAT_FULL_BIT(STAT_FULL_BIT), .STAT_AUX_BIT(STAT_AUX_BIT),
  .PORT_FULL_BIT(PORT_FULL_BIT), .PORT_AUX_BIT(PORT_AUX_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .kbd_pend(kbd_pend), .aux_pend(aux_pend),
  .mode(mode), .stat_mask(stat_mask), .port_mask(port_mask),
  .pop_kbd(pop_kbd), .pop_aux(pop_aux), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
);

// File: tb/obuf_irq_arbiter_test.sv
module obuf_irq_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_pend = 1'b0, aux_pend = 1'b0, rd_strobe = 1'b0;
  logic [7:0] mode = 8'h00;
  logic [7:0] stat_mask, port_mask;
  logic       rd_sel_aux, pop_kbd, pop_aux, irq_kbd, irq_aux;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  obuf_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .kbd_pend(kbd_pend), .aux_pend(aux_pend),
    .mode(mode), .rd_strobe(rd_strobe), .stat_mask(stat_mask),
    .port_mask(port_mask), .rd_sel_aux(rd_sel_aux), .pop_kbd(pop_kbd),
    .pop_aux(pop_aux), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  function automatic logic [7:0] exp_stat(logic k, logic a);
    return {2'b00, a & ~k, 4'b0000, k | a};
  endfunction

  function automatic logic [7:0] exp_port(logic k, logic a);
    return {2'b00, a & ~k, k | a, 4'b0000};
  endfunction

  function automatic logic exp_ik(logic k, logic [7:0] m);
    return k & m[0] & ~m[4];
  endfunction

  function automatic logic exp_ia(logic k, logic a, logic [7:0] m);
    return a & ~k & m[1];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_comb();
    logic sa;
    sa = aux_pend & ~kbd_pend;
    chk("R1/R2/R3 stat", stat_mask, exp_stat(kbd_pend, aux_pend));
    chk("R1/R2/R3 port", port_mask, exp_port(kbd_pend, aux_pend));
    chk("R6 select", {7'd0, rd_sel_aux}, {7'd0, sa});
    chk("R7 pops", {6'd0, pop_kbd, pop_aux},
        {6'd0, rd_strobe & ~sa, rd_strobe & sa});
  endtask

  // Drive at negedge, check combinational, then check IRQs after the edge.
  task automatic step(logic k, logic a, logic [7:0] m, logic s);
    logic ek, ea;
    @(negedge clk);
    kbd_pend = k; aux_pend = a; mode = m; rd_strobe = s;
    #1 check_comb();
    ek = exp_ik(k, m);
    ea = exp_ia(k, a, m);
    @(posedge clk);
    #1;
    chk("R5 irq_kbd", {7'd0, irq_kbd}, {7'd0, ek});
    chk("R4 irq_aux", {7'd0, irq_aux}, {7'd0, ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    // R8: reset holds IRQs low even with data pending and enables set
    kbd_pend = 1'b1; aux_pend = 1'b0; mode = 8'h03;
    repeat (3) @(posedge clk);
    #1 chk("R8 reset irqs", {6'd0, irq_kbd, irq_aux}, 8'd0);
    @(negedge clk) rst_n = 1'b1;

    // directed corner cases
    step(1'b0, 1'b0, 8'h03, 1'b1);   // nothing pending, read goes to kbd
    step(1'b1, 1'b1, 8'h03, 1'b1);   // both: keyboard wins (R2)
    step(1'b0, 1'b1, 8'h03, 1'b1);   // aux only (R4, R6)
    step(1'b0, 1'b1, 8'h01, 1'b0);   // aux enable off
    step(1'b1, 1'b0, 8'h13, 1'b0);   // keyboard disabled (R5)
    step(1'b1, 1'b0, 8'h03, 1'b0);   // mode-only change raises irq (R9)
    step(1'b1, 1'b0, 8'hEF, 1'b1);   // R9: unused bits set, kbd enabled
    step(1'b0, 1'b1, 8'hEE, 1'b0);   // R9: unused bits set, aux enabled
    step(1'b0, 1'b1, 8'hEC, 1'b0);   // R9: unused bits, aux enable clear

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] m;
      m = 8'($urandom());
      if (($urandom() % 4) == 0) m[4] = 1'b0;
      step(1'($urandom()), 1'($urandom()), m, 1'($urandom()));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule